// File: doc/BRIEF.md
# Transmit Frame FIFO with Start Threshold and Self-Clearing Flush

The block buffers outgoing frame bytes between a DMA engine that writes them and a MAC transmitter that reads them. Each stored byte carries an end-of-frame marker, so the FIFO knows where frames begin and end. It does not decide what the bytes mean. It decides only when the reader may begin taking a frame.

There are two start policies. In store-and-forward mode, a frame is offered only once its last byte is inside the FIFO. In cut-through mode, a frame is offered once the stored byte count reaches a programmable threshold, or earlier if the frame's end marker is already stored. A configuration write can request a flush. The flush discards everything, keeps both sides idle for a fixed number of cycles, and then clears its busy flag by itself. While the flag is set, configuration writes are refused. A new store-and-forward setting takes effect only when no frame is being read out.

Top module: `tx_frame_fifo`

## Requirements
- R1: After reset the FIFO is empty, `rdValid` is 0, `wrReady` is 1 and `flushBusy` is 0. The block starts in cut-through mode with threshold code 0.
- R2: Bytes and their end markers leave the read side in the order they were written, with no loss or duplication.
- R3: When store-and-forward is active, the first byte of a frame is offered only after that frame's end-marked byte has been stored. The threshold code has no effect in this mode.
- R4: In cut-through mode, an idle reader is offered the head frame once the stored byte count reaches the threshold. Codes 0,1,2,3 select 64,128,192,256 bytes and codes 4,5,6,7 select 40,32,24,16 bytes.
- R5: In cut-through mode, a frame whose end-marked byte is stored is offered even if the byte count is below the threshold.
- R6: Once a frame has started, the start policy does not apply to it. Any stored byte of that frame is offered. A store-and-forward change written mid-frame takes effect only after that frame's last byte is read.
- R7: A configuration write with the flush bit set discards all stored data. `flushBusy` is 1 for exactly FLUSH_CYCLES cycles (4 by default) and then returns to 0 without further action.
- R8: While a flush is in progress, `wrReady` and `rdValid` are both 0. After the flush the FIFO is empty.
- R9: A configuration write made while `flushBusy` is 1 is ignored entirely. It changes neither the mode nor the threshold.
- R10: `wrReady` is 0 when DEPTH bytes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgStoreFwd | input | 1 | Store-and-forward select written by cfgWrite |
| cfgThresh | input | 3 | Cut-through threshold code written by cfgWrite |
| cfgFlush | input | 1 | Flush request written by cfgWrite |
| flushBusy | output | 1 | Flush in progress; reads back as the flush bit |
| wrValid | input | 1 | Write side byte valid |
| wrReady | output | 1 | Write side can accept a byte |
| wrData | input | DATA_W | Byte written |
| wrLast | input | 1 | Byte written ends its frame |
| rdValid | output | 1 | Read side byte offered |
| rdReady | input | 1 | Read side takes the offered byte |
| rdData | output | DATA_W | Byte offered |
| rdLast | output | 1 | Offered byte ends its frame |

## Verification
The bench uses the defaults DEPTH=256, DATA_W=8 and FLUSH_CYCLES=4. With DEPTH equal to the largest threshold, every threshold code can be reached, including the 256-byte code, which fires only when the FIFO is completely full. That same fill also reaches the full condition. The 4-cycle flush is short enough to check cycle by cycle, and a configuration write can be placed inside it. Random frames up to 80 bytes, with random reader stalls, let writes and reads overlap in both modes.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCmd_t;

  // Cut-through start threshold in bytes for a 3-bit code
  function automatic logic [9:0] thresholdBytes(input logic [2:0] code);
    if (!code[2]) thresholdBytes = 10'(({8'd0, code[1:0]} + 10'd1) << 6);
    else          thresholdBytes = 10'd40 - 10'({code[1:0], 3'b000});
  endfunction

endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store
  import tx_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast,
  output logic [CW-1:0]     level,
  output logic [CW-1:0]     frames,
  output logic              full
);

  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic            doPush, doPop;

  assign doPush = cmd.push && !cmd.clear;
  assign doPop  = cmd.pop  && !cmd.clear;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {wrLast, wrData};
  end

  assign {rdLast, rdData} = mem[rdPtr];
  assign full = (level == CW'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      frames <= '0;
    end else if (cmd.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      frames <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      level  <= level + CW'(doPush) - CW'(doPop);
      frames <= frames + CW'(doPush && wrLast) - CW'(doPop && rdLast);
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> level < CW'(DEPTH));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |-> level != '0);

endmodule

// File: rtl/tx_fifo_ctrl.sv
module tx_fifo_ctrl
  import tx_fifo_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int FLUSH_CYCLES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FW = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrite,
  input  logic          cfgStoreFwd,
  input  logic [2:0]    cfgThresh,
  input  logic          cfgFlush,
  input  logic          wrValid,
  input  logic          rdReady,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] frames,
  input  logic          full,
  input  logic          headLast,
  output fifoCmd_t      cmd,
  output logic          wrReady,
  output logic          rdValid,
  output logic          flushBusy
);

  logic [FW-1:0] flushCnt;
  logic [2:0]    thrCode;
  logic          sfPending, sfMode;
  logic          active;
  logic          cfgTaken, flushStart, startOk;
  logic [9:0]    thrBytes;

  assign flushBusy  = (flushCnt != '0);
  assign cfgTaken   = cfgWrite && !flushBusy;
  assign flushStart = cfgTaken && cfgFlush;
  assign thrBytes   = thresholdBytes(thrCode);

  assign startOk = sfMode ? (frames != '0)
                          : ((frames != '0) || (int'(level) >= int'(thrBytes)));

  assign wrReady = !flushBusy && !flushStart && !full;
  assign rdValid = !flushBusy && !flushStart && (level != '0) && (active || startOk);

  assign cmd.push  = wrValid && wrReady;
  assign cmd.pop   = rdValid && rdReady;
  assign cmd.clear = flushStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushCnt  <= '0;
      thrCode   <= '0;
      sfPending <= 1'b0;
      sfMode    <= 1'b0;
      active    <= 1'b0;
    end else begin
      if (flushStart)     flushCnt <= FW'(FLUSH_CYCLES);
      else if (flushBusy) flushCnt <= flushCnt - FW'(1);

      if (cfgTaken) begin
        thrCode   <= cfgThresh;
        sfPending <= cfgStoreFwd;
      end

      if (!active) sfMode <= sfPending;

      if (flushStart)   active <= 1'b0;
      else if (cmd.pop) active <= !headLast;
    end
  end

  // R7
  flush_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushStart |=> flushBusy);

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> (!rdValid && !wrReady));

  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && flushBusy) |=> ($stable(thrCode) && $stable(sfPending)));

  // R3
  sf_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !active && sfMode) |-> (frames != '0));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |=> $stable(sfMode));

endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
  import tx_fifo_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 256,
  parameter int FLUSH_CYCLES = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic              cfgStoreFwd,
  input  logic [2:0]        cfgThresh,
  input  logic              cfgFlush,
  output logic              flushBusy,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast
);

  fifoCmd_t      cmd;
  logic [CW-1:0] level, frames;
  logic          full;

  tx_fifo_ctrl #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) uCtrl (
    .clk, .rstN, .cfgWrite, .cfgStoreFwd, .cfgThresh, .cfgFlush,
    .wrValid, .rdReady, .level, .frames, .full, .headLast(rdLast),
    .cmd, .wrReady, .rdValid, .flushBusy
  );

  tx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uStore (
    .clk, .rstN, .cmd, .wrData, .wrLast, .rdData, .rdLast,
    .level, .frames, .full
  );

endmodule

// File: tb/sim_tx_frame_fifo.sv
module sim_tx_frame_fifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrite = 0, cfgStoreFwd = 0, cfgFlush = 0;
  logic [2:0] cfgThresh = 0;
  logic       flushBusy, wrReady, rdValid, rdLast;
  logic       wrValid = 0, wrLast = 0, rdReady = 0;
  logic [7:0] wrData = 0, rdData;

  int checks = 0, fails = 0;
  logic [8:0] expQ[$];
  logic [8:0] genQ[$];

  always #5 clk = ~clk;

  tx_frame_fifo u0 (.*);

  function automatic int thrOf(input int code);
    return (code < 4) ? 64 * (code + 1) : 40 - 8 * (code - 4);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input bit sf, input int thr, input bit fl);
    cfgWrite = 1; cfgStoreFwd = sf; cfgThresh = 3'(thr); cfgFlush = fl;
    @(posedge clk); @(negedge clk);
    cfgWrite = 0; cfgFlush = 0;
  endtask

  task automatic wr(input logic [7:0] d, input bit l);
    wrValid = 1; wrData = d; wrLast = l;
    #1 chk(wrReady, "R10", wrReady, 1);
    expQ.push_back({l, d});
    @(posedge clk); @(negedge clk);
    wrValid = 0; wrLast = 0;
  endtask

  task automatic wrMany(input int n, input bit lastAtEnd);
    for (int i = 0; i < n; i++) wr(8'($urandom), lastAtEnd && (i == n - 1));
  endtask

  task automatic rdOne();
    logic [8:0] e;
    rdReady = 1;
    #1 e = expQ.pop_front();
    chk(rdValid, "R2", rdValid, 1);
    chk({rdLast, rdData} == e, "R2", {rdLast, rdData}, e);
    @(posedge clk); @(negedge clk);
    rdReady = 0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) rdOne();
  endtask

  task automatic doFlush();
    cfg(0, 0, 1);
    while (flushBusy) @(negedge clk);
    expQ.delete();
  endtask

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!rdValid, "R1", rdValid, 0);
    chk(wrReady, "R1", wrReady, 1);
    chk(!flushBusy, "R1", flushBusy, 0);
    wrMany(63, 0);
    chk(!rdValid, "R1", rdValid, 0);
    wr(8'h11, 0);
    chk(rdValid, "R1", rdValid, 1);
    wr(8'h12, 1);
    drain();

    // R4 every threshold code in cut-through mode
    for (int c = 0; c < 8; c++) begin
      cfg(0, c, 0); @(negedge clk);
      wrMany(thrOf(c) - 1, 0);
      chk(!rdValid, "R4", rdValid, 0);
      if (c == 3) begin
        wr(8'hA5, 0);
        chk(rdValid, "R4", rdValid, 1);
        // R10 full at 256 stored
        chk(!wrReady, "R10", wrReady, 0);
        rdOne();
        wr(8'h5A, 1);
      end else begin
        wr(8'hA5, 0);
        chk(rdValid, "R4", rdValid, 1);
        wr(8'h5A, 1);
      end
      drain();
    end

    // R5 short frame in cut-through
    cfg(0, 0, 0); @(negedge clk);
    wrMany(4, 0);
    chk(!rdValid, "R5", rdValid, 0);
    wr(8'h77, 1);
    chk(rdValid, "R5", rdValid, 1);
    drain();

    // R3 store-and-forward ignores threshold
    cfg(1, 7, 0); @(negedge clk);
    wrMany(100, 0);
    chk(!rdValid, "R3", rdValid, 0);
    wr(8'h33, 1);
    chk(rdValid, "R3", rdValid, 1);
    drain();

    // R6 mode change mid-frame
    cfg(0, 7, 0); @(negedge clk);
    wrMany(16, 0);
    chk(rdValid, "R6", rdValid, 1);
    cfg(1, 7, 0);
    for (int i = 0; i < 16; i++) rdOne();
    wr(8'h66, 0);
    chk(rdValid, "R6", rdValid, 1);
    wr(8'h67, 1);
    drain();
    @(negedge clk);
    wrMany(20, 0);
    chk(!rdValid, "R6", rdValid, 0);

    // R7 R8 R9 flush mid-frame, config write during flush
    cfg(1, 7, 1);
    expQ.delete();
    for (int i = 0; i < 4; i++) begin
      if (i == 0) begin cfgWrite = 1; cfgStoreFwd = 0; cfgThresh = 3'd7; end
      chk(flushBusy, "R7", flushBusy, 1);
      chk(!wrReady, "R8", wrReady, 0);
      chk(!rdValid, "R8", rdValid, 0);
      @(posedge clk); @(negedge clk);
      cfgWrite = 0;
    end
    chk(!flushBusy, "R7", flushBusy, 0);
    chk(!rdValid, "R8", rdValid, 0);
    chk(wrReady, "R8", wrReady, 1);
    wrMany(20, 0);
    chk(!rdValid, "R9", rdValid, 0);
    wr(8'h99, 1);
    chk(rdValid, "R9", rdValid, 1);
    drain();

    // R2 random frames in both modes with reader stalls
    for (int b = 0; b < 4; b++) begin
      int idxW, idxR;
      doFlush();
      cfg(b[0], $urandom % 8, 0); @(negedge clk);
      genQ.delete();
      for (int f = 0; f < 8; f++) begin
        int len;
        len = 1 + $urandom % 80;
        for (int i = 0; i < len; i++) genQ.push_back({(i == len - 1), 8'($urandom)});
      end
      idxW = 0; idxR = 0;
      fork
        while (idxW < genQ.size()) begin
          wrValid = ($urandom % 4) != 0;
          wrData = genQ[idxW][7:0]; wrLast = genQ[idxW][8];
          #1 if (wrValid && wrReady) idxW++;
          @(negedge clk);
        end
        while (idxR < genQ.size()) begin
          rdReady = ($urandom % 3) != 0;
          #1 if (rdValid && rdReady) begin
            chk({rdLast, rdData} == genQ[idxR], "R2", {rdLast, rdData}, genQ[idxR]);
            idxR++;
          end
          @(negedge clk);
        end
      join
      wrValid = 0; rdReady = 0; wrLast = 0;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule